// File: doc/BRIEF.md
# USB Host Controller Register Block

This block is the software-visible control core of a USB 1.1 style host controller. A host bus reaches it through byte, word and dword accesses inside a 32-byte window. Behind that window it keeps the command word, a write-one-to-clear status word, an interrupt-enable word, an 11-bit frame counter, the frame-list base address and the SOF timing byte. It drives one level-sensitive interrupt line.

The frame scheduler sits beside it. The scheduler sees `run_o` and the frame-list base, and it reports back through a frame strobe that carries a two-bit end-of-frame interrupt request, through error strobes and through a resume event. Writing a reset command clears the register state. A global reset also sends a one-cycle bus-reset pulse to every downstream port.

Two causes share the completion-interrupt status bit: completion on request and short packet. A hidden two-bit cause register keeps them apart so that each one can be enabled on its own.

Top module: `usb_hc_regs`

## Requirements
- R1: After rst_ni the block holds these values: command 0, status 0, interrupt enable 0, frame number 0, list base 0, SOF timing 64 (0x40). `irq_o`, `run_o` and `port_bus_reset_o` are all 0.
- R2: The access offset is the address modulo 32. Size code 0 is a byte access, 1 is a word access and 2 is a dword access. The word registers are: command at 0x00, status at 0x02, interrupt enable at 0x04 and frame number at 0x06. The dword register is the list base at 0x08, and the byte register is SOF timing at 0x0C. Read data sits in the low bits and the upper bits are zero.
- R3: A read of an unimplemented offset/size returns 0xFF for a byte access, 0xFF7F for a word access, and 0xFFFFFFFF for a dword access or size code 3. A write to an unimplemented offset/size changes nothing.
- R4: A command write stores its 16-bit value, and `run_o` follows bit 0 of the command. A write that sets bit 0 while it was clear clears halted (status bit 5). A write with bit 0 clear sets halted. A write with bit 0 set while it was already set leaves halted unchanged.
- R5: A command write with bit 1 (controller reset) or bit 2 (global reset) set is not stored. It sets command, status, cause, interrupt enable and list base to 0 and SOF timing to 64, and it leaves the frame number unchanged.
- R6: A global-reset write drives all bits of `port_bus_reset_o` high for exactly the one cycle after the write. A controller-reset write alone leaves `port_bus_reset_o` low.
- R7: A status write clears each status bit that is written as one and leaves the other bits unchanged. Writing one to bit 0 also clears both cause bits.
- R8: A frame strobe while command bit 0 is set advances the frame number modulo 2048. It also ORs `frame_irq_i` into the cause register and sets status bit 0 when that request is nonzero. A frame strobe while command bit 0 is clear does not move the frame number and sets halted.
- R9: A word write to the frame number takes effect only while halted is set, and it keeps only the low 11 bits.
- R10: A list-base write keeps bits 31:12. Bits 11:0 always read as zero.
- R11: When command bit 3 (suspend) is set, `resume_i` sets command bit 4 and status bit 2. When command bit 3 is clear, `resume_i` has no effect.
- R12: `irq_o` is registered and follows its sources one cycle after they change. It is high if any of these holds:
  - cause bit 0 and enable bit 2 are both set;
  - cause bit 1 and enable bit 3 are both set;
  - status bit 1 and enable bit 0 are both set;
  - status bit 2 and enable bit 1 are both set;
  - status bit 3 is set;
  - status bit 4 is set.
- R13: The strobes `txn_err_i`, `host_err_i` and `proc_err_i` set status bits 1, 3 and 4 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_wr_i | input | 1 | Write strobe for the current access |
| acc_size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| acc_addr_i | input | ADDR_W | Access address; bits 4:0 are decoded |
| acc_wdata_i | input | 32 | Write data, low-aligned |
| acc_rdata_o | output | 32 | Read data for the presented address and size |
| frame_tick_i | input | 1 | Frame boundary strobe from the scheduler |
| frame_irq_i | input | 2 | End-of-frame interrupt request (bit 0 completion, bit 1 short packet) |
| txn_err_i | input | 1 | Transaction error strobe |
| host_err_i | input | 1 | Host system error strobe |
| proc_err_i | input | 1 | Process error strobe |
| resume_i | input | 1 | Resume event from a port |
| run_o | output | 1 | Controller is running |
| frame_num_o | output | FRAME_W | Current frame number |
| list_base_o | output | 32 | Frame-list base address |
| sof_timing_o | output | 8 | SOF timing value |
| port_bus_reset_o | output | N_PORTS | One-cycle bus-reset pulse per port |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: N_PORTS=2, FRAME_W=11 and ADDR_W=16. With a 16-bit address it can drive aliased offsets such as 0x24 and 0x2C and confirm that decoding wraps at 32. With an 11-bit frame counter it can load 0x7FF while halted and then show the wrap to 0 on a single strobe while running. With two ports it can check the global-reset pulse as a multi-bit all-ones value.

// File: rtl/usb_hc_regs_pkg.sv
package usb_hc_regs_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} acc_size_e;

  localparam logic [4:0] OFS_CMD    = 5'h00;
  localparam logic [4:0] OFS_STS    = 5'h02;
  localparam logic [4:0] OFS_IEN    = 5'h04;
  localparam logic [4:0] OFS_FRNUM  = 5'h06;
  localparam logic [4:0] OFS_FLBASE = 5'h08;
  localparam logic [4:0] OFS_SOF    = 5'h0C;

  localparam int CMD_RUN   = 0;
  localparam int CMD_HCRST = 1;
  localparam int CMD_GRST  = 2;
  localparam int CMD_SUSP  = 3;
  localparam int CMD_FRES  = 4;

  localparam int ST_DONE    = 0;
  localparam int ST_TXERR   = 1;
  localparam int ST_RESUME  = 2;
  localparam int ST_SYSERR  = 3;
  localparam int ST_PROCERR = 4;
  localparam int ST_HALT    = 5;
  localparam int ST_W       = 6;
endpackage

// File: rtl/usb_hc_frame_ctr.sv
module usb_hc_frame_ctr #(
  parameter int FRAME_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_val_i,
  input  logic               adv_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_q <= '0;
    else if (load_i) frame_q <= load_val_i;
    else if (adv_i)  frame_q <= frame_q + 1'b1;
  end

  assign frame_o = frame_q;

  // R8
  frame_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> frame_q == $past(frame_q) + 1'b1);

  // R8
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(frame_q));
endmodule

// File: rtl/usb_hc_irq.sv
module usb_hc_irq
  import usb_hc_regs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] sts_i,
  input  logic [1:0]      cause_i,
  input  logic [3:0]      ien_i,
  output logic            irq_o
);
  logic irq_d, irq_q;

  always_comb begin
    irq_d = (cause_i[0] & ien_i[2]) | (cause_i[1] & ien_i[3]) |
            (sts_i[ST_TXERR] & ien_i[0]) | (sts_i[ST_RESUME] & ien_i[1]) |
            sts_i[ST_SYSERR] | sts_i[ST_PROCERR];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R12: unmaskable error causes
  fatal_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[ST_SYSERR] || sts_i[ST_PROCERR]) |=> irq_o);

  // R12: no source, no interrupt
  quiet_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[4:1] == 4'b0 && cause_i == 2'b0) |=> !irq_o);
endmodule

// File: rtl/usb_hc_rdmux.sv
module usb_hc_rdmux
  import usb_hc_regs_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int FRAME_W  = 11,
  parameter int BASE_LSB = 12
) (
  input  logic [1:0]           size_i,
  input  logic [4:0]           ofs_i,
  input  logic [REG_W-1:0]     cmd_i,
  input  logic [ST_W-1:0]      sts_i,
  input  logic [REG_W-1:0]     ien_i,
  input  logic [FRAME_W-1:0]   frame_i,
  input  logic [31:BASE_LSB]   base_i,
  input  logic [7:0]           sof_i,
  output logic [31:0]          rdata_o
);
  logic [15:0] word_v;

  always_comb begin
    case (ofs_i)
      OFS_CMD:   word_v = 16'(cmd_i);
      OFS_STS:   word_v = 16'(sts_i);
      OFS_IEN:   word_v = 16'(ien_i);
      OFS_FRNUM: word_v = 16'(frame_i);
      default:   word_v = 16'hFF7F;
    endcase
  end

  always_comb begin
    case (size_i)
      SZ_BYTE:  rdata_o = {24'h0, (ofs_i == OFS_SOF) ? sof_i : 8'hFF};
      SZ_WORD:  rdata_o = {16'h0, word_v};
      SZ_DWORD: rdata_o = (ofs_i == OFS_FLBASE) ? {base_i, {BASE_LSB{1'b0}}} : 32'hFFFF_FFFF;
      default:  rdata_o = 32'hFFFF_FFFF;
    endcase
  end
endmodule

// File: rtl/usb_hc_regs.sv
module usb_hc_regs
  import usb_hc_regs_pkg::*;
#(
  parameter int          N_PORTS = 2,
  parameter int          ADDR_W  = 16,
  parameter int          FRAME_W = 11,
  parameter logic [7:0]  SOF_RST = 8'd64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_wr_i,
  input  logic [1:0]         acc_size_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [31:0]        acc_wdata_i,
  output logic [31:0]        acc_rdata_o,
  input  logic               frame_tick_i,
  input  logic [1:0]         frame_irq_i,
  input  logic               txn_err_i,
  input  logic               host_err_i,
  input  logic               proc_err_i,
  input  logic               resume_i,
  output logic               run_o,
  output logic [FRAME_W-1:0] frame_num_o,
  output logic [31:0]        list_base_o,
  output logic [7:0]         sof_timing_o,
  output logic [N_PORTS-1:0] port_bus_reset_o,
  output logic               irq_o
);
  localparam int REG_W    = 16;
  // list holds 2^(FRAME_W-1) four-byte entries
  localparam int BASE_LSB = FRAME_W + 1;

  logic [4:0] ofs;
  logic       unused_addr;
  assign ofs         = acc_addr_i[4:0];
  assign unused_addr = ^acc_addr_i[ADDR_W-1:5];

  logic wr_w, wr_cmd, wr_sts, wr_ien, wr_frn, wr_base, wr_sof;
  logic rst_req, grst_req, run_adv, resume_hit;

  logic [REG_W-1:0]   cmd_q, ien_q;
  logic [ST_W-1:0]    sts_q, sts_d;
  logic [1:0]         cause_q, cause_d;
  logic [31:BASE_LSB] base_q;
  logic [7:0]         sof_q;
  logic [N_PORTS-1:0] bus_rst_q;

  assign wr_w     = acc_wr_i && (acc_size_i == SZ_WORD);
  assign wr_cmd   = wr_w && (ofs == OFS_CMD);
  assign wr_sts   = wr_w && (ofs == OFS_STS);
  assign wr_ien   = wr_w && (ofs == OFS_IEN);
  assign wr_frn   = wr_w && (ofs == OFS_FRNUM);
  assign wr_base  = acc_wr_i && (acc_size_i == SZ_DWORD) && (ofs == OFS_FLBASE);
  assign wr_sof   = acc_wr_i && (acc_size_i == SZ_BYTE) && (ofs == OFS_SOF);
  assign rst_req  = wr_cmd && (acc_wdata_i[CMD_HCRST] || acc_wdata_i[CMD_GRST]);
  assign grst_req = wr_cmd && acc_wdata_i[CMD_GRST];
  assign run_adv  = frame_tick_i && cmd_q[CMD_RUN];
  assign resume_hit = resume_i && cmd_q[CMD_SUSP];

  always_comb begin
    sts_d   = sts_q;
    cause_d = cause_q;
    if (wr_sts) begin
      sts_d = sts_d & ~acc_wdata_i[ST_W-1:0];
      if (acc_wdata_i[ST_DONE]) cause_d = 2'b00;
    end
    if (wr_cmd) begin
      if (acc_wdata_i[CMD_RUN] && !cmd_q[CMD_RUN]) sts_d[ST_HALT] = 1'b0;
      else if (!acc_wdata_i[CMD_RUN])              sts_d[ST_HALT] = 1'b1;
    end
    if (frame_tick_i && !cmd_q[CMD_RUN]) sts_d[ST_HALT] = 1'b1;
    if (run_adv) begin
      cause_d = cause_d | frame_irq_i;
      if (|frame_irq_i) sts_d[ST_DONE] = 1'b1;
    end
    if (txn_err_i)  sts_d[ST_TXERR]   = 1'b1;
    if (host_err_i) sts_d[ST_SYSERR]  = 1'b1;
    if (proc_err_i) sts_d[ST_PROCERR] = 1'b1;
    if (resume_hit) sts_d[ST_RESUME]  = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      sts_q   <= '0;
      cause_q <= '0;
      ien_q   <= '0;
      base_q  <= '0;
      sof_q   <= SOF_RST;
    end else if (rst_req) begin
      cmd_q   <= '0;
      sts_q   <= '0;
      cause_q <= '0;
      ien_q   <= '0;
      base_q  <= '0;
      sof_q   <= SOF_RST;
    end else begin
      if (wr_cmd)     cmd_q <= acc_wdata_i[REG_W-1:0];
      if (resume_hit) cmd_q[CMD_FRES] <= 1'b1;
      sts_q   <= sts_d;
      cause_q <= cause_d;
      if (wr_ien)  ien_q  <= acc_wdata_i[REG_W-1:0];
      if (wr_base) base_q <= acc_wdata_i[31:BASE_LSB];
      if (wr_sof)  sof_q  <= acc_wdata_i[7:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_rst_q <= '0;
    else         bus_rst_q <= {N_PORTS{grst_req}};
  end

  usb_hc_frame_ctr #(.FRAME_W(FRAME_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_frn && sts_q[ST_HALT]),
    .load_val_i (acc_wdata_i[FRAME_W-1:0]),
    .adv_i      (run_adv),
    .frame_o    (frame_num_o)
  );

  usb_hc_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sts_i   (sts_q),
    .cause_i (cause_q),
    .ien_i   (ien_q[3:0]),
    .irq_o   (irq_o)
  );

  usb_hc_rdmux #(.REG_W(REG_W), .FRAME_W(FRAME_W), .BASE_LSB(BASE_LSB)) u_rdmux (
    .size_i  (acc_size_i),
    .ofs_i   (ofs),
    .cmd_i   (cmd_q),
    .sts_i   (sts_q),
    .ien_i   (ien_q),
    .frame_i (frame_num_o),
    .base_i  (base_q),
    .sof_i   (sof_q),
    .rdata_o (acc_rdata_o)
  );

  assign run_o            = cmd_q[CMD_RUN];
  assign list_base_o      = {base_q, {BASE_LSB{1'b0}}};
  assign sof_timing_o     = sof_q;
  assign port_bus_reset_o = bus_rst_q;

  // R5
  cmd_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> (cmd_q == '0 && ien_q == '0 && sof_q == SOF_RST && base_q == '0));

  // R6
  bus_rst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|port_bus_reset_o) |-> $past(grst_req));

  // R7
  sts_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts && !frame_tick_i && !txn_err_i && !host_err_i && !proc_err_i && !resume_i)
      |=> (sts_q & $past(acc_wdata_i[ST_W-1:0])) == '0);

  // R4
  run_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && !rst_req && acc_wdata_i[CMD_RUN] && !cmd_q[CMD_RUN]) |=> (run_o && !sts_q[ST_HALT]));
endmodule

// File: tb/tb_usb_hc_regs.sv
`timescale 1ns/1ps
module tb_usb_hc_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0;
  logic [1:0]  acc_size = 2'd1;
  logic [15:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        tick = 1'b0;
  logic [1:0]  fmask = 2'b00;
  logic        txn_err = 1'b0, host_err = 1'b0, proc_err = 1'b0, resume = 1'b0;
  logic        run;
  logic [10:0] frame_num;
  logic [31:0] list_base;
  logic [7:0]  sof_timing;
  logic [1:0]  bus_rst;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usb_hc_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_wr_i(acc_wr), .acc_size_i(acc_size),
    .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata),
    .frame_tick_i(tick), .frame_irq_i(fmask), .txn_err_i(txn_err),
    .host_err_i(host_err), .proc_err_i(proc_err), .resume_i(resume),
    .run_o(run), .frame_num_o(frame_num), .list_base_o(list_base),
    .sof_timing_o(sof_timing), .port_bus_reset_o(bus_rst), .irq_o(irq)
  );

  localparam logic [1:0] B = 2'd0, W = 2'd1, D = 2'd2;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0, W, 16'h02, 32'h0,        32'h0,        4'd1},  // R1
    '{1'b0, B, 16'h0C, 32'h0,        32'h40,       4'd1},  // R1
    '{1'b1, W, 16'h04, 32'h000F,     32'h0,        4'd0},
    '{1'b0, W, 16'h04, 32'h0,        32'h000F,     4'd2},  // R2
    '{1'b0, W, 16'h24, 32'h0,        32'h000F,     4'd2},  // R2 alias
    '{1'b1, D, 16'h08, 32'h12345678, 32'h0,        4'd0},
    '{1'b0, D, 16'h08, 32'h0,        32'h12345000, 4'd10}, // R10
    '{1'b1, B, 16'h2C, 32'hA5,       32'h0,        4'd0},
    '{1'b0, B, 16'h0C, 32'h0,        32'hA5,       4'd2},  // R2
    '{1'b0, B, 16'h00, 32'h0,        32'hFF,       4'd3},  // R3
    '{1'b0, W, 16'h10, 32'h0,        32'hFF7F,     4'd3},  // R3
    '{1'b0, D, 16'h00, 32'h0,        32'hFFFFFFFF, 4'd3},  // R3
    '{1'b1, D, 16'h00, 32'h1,        32'h0,        4'd0},
    '{1'b0, W, 16'h00, 32'h0,        32'h0,        4'd3},  // R3
    '{1'b1, W, 16'h06, 32'h0ABC,     32'h0,        4'd0},
    '{1'b0, W, 16'h06, 32'h0,        32'h0,        4'd9},  // R9
    '{1'b1, W, 16'h00, 32'h0,        32'h0,        4'd0},
    '{1'b0, W, 16'h02, 32'h0,        32'h20,       4'd4},  // R4
    '{1'b1, W, 16'h06, 32'h0FFF,     32'h0,        4'd0},
    '{1'b0, W, 16'h06, 32'h0,        32'h07FF,     4'd9},  // R9
    '{1'b1, W, 16'h04, 32'h0,        32'h0,        4'd0},
    '{1'b1, W, 16'h00, 32'h1,        32'h0,        4'd0},
    '{1'b0, W, 16'h02, 32'h0,        32'h0,        4'd4},  // R4
    '{1'b0, W, 16'h00, 32'h0,        32'h1,        4'd4}   // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_size = sz; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_size = sz; acc_addr = a;
    #1 d = acc_rdata;
  endtask

  task automatic ftick(input logic [1:0] m);
    @(negedge clk);
    tick = 1'b1; fmask = m;
    @(negedge clk);
    tick = 1'b0; fmask = 2'b00;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 run", {31'b0, run}, 32'h0);
    chk("R1 bus_rst", {30'b0, bus_rst}, 32'h0);
    chk("R1 frame", {21'b0, frame_num}, 32'h0);
    chk("R1 base", list_base, 32'h0);
    chk("R1 sof", {24'b0, sof_timing}, 32'd64);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].sz, VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].sz, VEC[i].addr, v);
        chk($sformatf("R%0d vec%0d", VEC[i].tag, i), v, VEC[i].exp);
      end
    end
    chk("R4 run_o", {31'b0, run}, 32'h1);

    // R8 wrap and cause capture
    ftick(2'b00);
    rd(W, 16'h06, v); chk("R8 wrap", v, 32'h0);
    ftick(2'b01);
    rd(W, 16'h06, v); chk("R8 advance", v, 32'h1);
    rd(W, 16'h02, v); chk("R8 done bit", v, 32'h1);
    wr(W, 16'h04, 32'h4);
    chk("R12 lag", {31'b0, irq}, 32'h0);
    cyc();
    chk("R12 cause0", {31'b0, irq}, 32'h1);
    wr(W, 16'h02, 32'h1);
    rd(W, 16'h02, v); chk("R7 clear", v, 32'h0);
    cyc();
    chk("R7 cause cleared", {31'b0, irq}, 32'h0);

    // cause bit 1
    wr(W, 16'h04, 32'h8);
    ftick(2'b10);
    cyc();
    chk("R12 cause1", {31'b0, irq}, 32'h1);
    wr(W, 16'h02, 32'h0);
    rd(W, 16'h02, v); chk("R7 zero write", v, 32'h1);
    cyc();
    chk("R7 irq kept", {31'b0, irq}, 32'h1);
    wr(W, 16'h02, 32'h1);
    cyc(); cyc();
    chk("R7 cause1 cleared", {31'b0, irq}, 32'h0);
    wr(W, 16'h04, 32'h0);

    // unmaskable errors
    @(negedge clk) host_err = 1'b1;
    @(negedge clk) host_err = 1'b0;
    rd(W, 16'h02, v); chk("R13 host err", v, 32'h8);
    cyc();
    chk("R12 host err irq", {31'b0, irq}, 32'h1);
    wr(W, 16'h02, 32'h8);
    cyc();
    chk("R12 host err clr", {31'b0, irq}, 32'h0);
    @(negedge clk) proc_err = 1'b1;
    @(negedge clk) proc_err = 1'b0;
    rd(W, 16'h02, v); chk("R13 proc err", v, 32'h10);
    cyc();
    chk("R12 proc err irq", {31'b0, irq}, 32'h1);
    wr(W, 16'h02, 32'h10);

    // maskable transaction error
    @(negedge clk) txn_err = 1'b1;
    @(negedge clk) txn_err = 1'b0;
    rd(W, 16'h02, v); chk("R13 txn err", v, 32'h2);
    cyc();
    chk("R12 txn masked", {31'b0, irq}, 32'h0);
    wr(W, 16'h04, 32'h1);
    cyc();
    chk("R12 txn enabled", {31'b0, irq}, 32'h1);
    wr(W, 16'h02, 32'h2);
    wr(W, 16'h04, 32'h0);

    // R11 resume
    @(negedge clk) resume = 1'b1;
    @(negedge clk) resume = 1'b0;
    rd(W, 16'h00, v); chk("R11 no suspend cmd", v, 32'h1);
    rd(W, 16'h02, v); chk("R11 no suspend sts", v, 32'h0);
    wr(W, 16'h00, 32'h9);
    @(negedge clk) resume = 1'b1;
    @(negedge clk) resume = 1'b0;
    rd(W, 16'h00, v); chk("R11 force resume", v, 32'h19);
    rd(W, 16'h02, v); chk("R11 resume detect", v, 32'h4);
    wr(W, 16'h04, 32'h2);
    cyc();
    chk("R12 resume irq", {31'b0, irq}, 32'h1);
    wr(W, 16'h02, 32'h4);
    wr(W, 16'h04, 32'h0);

    // R8 tick while stopped
    wr(W, 16'h00, 32'h0);
    ftick(2'b11);
    rd(W, 16'h06, v); chk("R8 stopped hold", v, 32'h2);
    rd(W, 16'h02, v); chk("R8 stopped halted", v, 32'h20);

    // R5 controller reset
    wr(W, 16'h04, 32'h3);
    wr(B, 16'h0C, 32'h11);
    wr(D, 16'h08, 32'hABCDE000);
    wr(W, 16'h00, 32'h2);
    chk("R6 no pulse on hc reset", {30'b0, bus_rst}, 32'h0);
    rd(W, 16'h00, v); chk("R5 cmd", v, 32'h0);
    rd(W, 16'h02, v); chk("R5 sts", v, 32'h0);
    rd(W, 16'h04, v); chk("R5 ien", v, 32'h0);
    rd(D, 16'h08, v); chk("R5 base", v, 32'h0);
    rd(B, 16'h0C, v); chk("R5 sof", v, 32'd64);
    rd(W, 16'h06, v); chk("R5 frame kept", v, 32'h2);

    // R6 global reset pulse
    wr(W, 16'h00, 32'h5);
    chk("R6 pulse", {30'b0, bus_rst}, 32'h3);
    rd(W, 16'h00, v); chk("R5 not stored", v, 32'h0);
    cyc();
    chk("R6 one cycle", {30'b0, bus_rst}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule